// File: doc/BRIEF.md
# Scan Chain Shift Engine

This block loads configuration bits into one of four serial scan chains. Software writes bytes into a small write FIFO through a memory-mapped port. A small engine reads the bytes from the FIFO head, finds command headers, and clocks each payload out one bit at a time to the chain that is currently enabled. Each chain has its own serial data output and scan clock. Software polls a status word that holds an active flag, the FIFO fill level and a sticky overflow flag.

Only one chain is enabled at a time. A packet is the byte 0x80, then a byte that holds the payload bit count minus one, then the payload bytes. A chain that is longer than one packet is sent as several packets in a row. The FIFO has three write ports: one for a single byte, one for a halfword and one for a word. Software can therefore send whole words and finish with single bytes. The engine reads only the payload bytes that the bit count needs, so any bytes that follow are parsed as the next command.

Top module: `scan_shift_engine`

## Requirements
- R1: After reset, the status word (offset 0x0) reads 0, the enable register (offset 0x4) reads 0, and every scan clock and data output is 0.
- R2: A write to the enable register at offset 0x4 takes effect only if bits 3:0 have at most one bit set. Bit n enables chain n. A write with two or more bits set leaves the register unchanged, and the register reads back at offset 0x4.
- R3: A write to offset 0x10 pushes bits 7:0. A write to offset 0x14 pushes bits 7:0 and then bits 15:8. A write to offset 0x18 pushes its four bytes from bits 7:0 up to bits 31:24. Each payload byte leaves the engine least significant bit first.
- R4: When the engine is idle, it starts a packet only on the byte 0x80 and drops any other byte. The byte after 0x80 holds N-1, and the engine then shifts exactly N payload bits. N=1 is valid.
- R5: The engine reads only ceil(N/8) payload bytes. In the last byte, the bits above the bit count are never shifted, and the next FIFO byte is parsed as a new command.
- R6: A packet with a length byte of 127 shifts 128 bits, taken from four words written in a row.
- R7: Each bit takes two clock cycles. The data line holds the bit in both cycles, and the scan clock is high only in the second cycle. At most one scan clock is high at a time, never in two cycles in a row, and only on the enabled chain. The clock and data outputs of every chain that is not enabled stay 0.
- R8: Status bit 31 goes to 1 on the clock edge that accepts a 0x80 header byte. It stays 1 while every bit of the packet is shifted, and it drops on the edge after the last scan clock high cycle.
- R9: Status bits 30:28 give the number of bytes in the FIFO, saturating at 7 when the 8-entry FIFO is full.
- R10: A FIFO write is dropped whole if the FIFO does not have enough free entries for all of its bytes. The drop sets status bit 0, which stays set until reset.
- R11: While no chain is enabled, the engine does not take any byte from the FIFO and does not start a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read byte offset |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| scan_tdi | output | 4 | Serial data, one line per chain |
| scan_tck | output | 4 | Scan clock, one line per chain |

## Verification
A register write takes effect on the clock edge where `wr_en` is sampled, and the status read reflects it straight after that edge. A header byte at the FIFO head sets the active flag one edge later. After that, each payload bit appears as a low-clock cycle followed by a high-clock cycle, and the active flag drops one edge after the final high cycle. The bench drives inputs on falling edges and samples 2 ns after each rising edge. A behavioural model checks every cycle: it holds queues of expected bits and packet lengths, pops one bit for each observed scan clock pulse, and checks the bit count of each packet when the active flag falls. The fill-level and overflow checks are made only after the write has had one full edge to land.

// File: rtl/scan_shift_engine.sv
module scan_shift_engine #(
  parameter int NCH   = 4,
  parameter int DEPTH = 8,
  parameter int AW    = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [31:0]    wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [31:0]    rd_data,
  output logic [NCH-1:0] scan_tdi,
  output logic [NCH-1:0] scan_tck
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_LEN, S_LOAD, S_SHIFT} st_t;

  logic [7:0]     mem [DEPTH];
  logic [PW-1:0]  wp, rp;
  logic [CW-1:0]  cnt;
  logic [NCH-1:0] chain_en;
  logic           ovf;
  st_t            st;
  logic           ph;
  logic [7:0]     sreg;
  logic [2:0]     bidx;
  logic [8:0]     left;
  logic [2:0]     nreq;

  always_comb begin
    nreq = 3'd0;
    if (wr_en) begin
      case (wr_addr)
        AW'(5'h10): nreq = 3'd1;
        AW'(5'h14): nreq = 3'd2;
        AW'(5'h18): nreq = 3'd4;
        default:    nreq = 3'd0;
      endcase
    end
  end

  wire       go     = |chain_en;
  wire [7:0] head   = mem[rp];
  wire       pop    = go && (cnt != '0) && (st != S_SHIFT);
  wire       fits   = (32'(cnt) + 32'(nreq)) <= 32'(DEPTH);
  wire       push   = (nreq != 3'd0) && fits;
  wire       drop   = (nreq != 3'd0) && !fits;
  wire       busy   = (st != S_IDLE);
  wire [NCH-1:0] en_wr  = wr_data[NCH-1:0];
  wire       en_ok  = (en_wr & (en_wr - NCH'(1))) == '0;
  wire [2:0] cnt_sat = (32'(cnt) > 7) ? 3'd7 : 3'(cnt);

  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++)
      if (push && k < int'(nreq))
        mem[wp + PW'(k)] <= wr_data[8*k +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      ovf      <= 1'b0;
      chain_en <= '0;
    end else begin
      if (push) wp <= wp + PW'(nreq);
      if (pop)  rp <= rp + PW'(1);
      cnt <= cnt + (push ? CW'(nreq) : CW'(0)) - (pop ? CW'(1) : CW'(0));
      if (drop) ovf <= 1'b1;
      if (wr_en && wr_addr == AW'(5'h04) && en_ok) chain_en <= en_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ph   <= 1'b0;
      sreg <= '0;
      bidx <= '0;
      left <= '0;
    end else begin
      case (st)
        S_IDLE: if (pop && head == 8'h80) st <= S_LEN;
        S_LEN:  if (pop) begin
          left <= {1'b0, head} + 9'd1;
          st   <= S_LOAD;
        end
        S_LOAD: if (pop) begin
          sreg <= head;
          bidx <= '0;
          ph   <= 1'b0;
          st   <= S_SHIFT;
        end
        S_SHIFT: if (go) begin
          ph <= ~ph;
          if (ph) begin
            sreg <= sreg >> 1;
            bidx <= bidx + 3'd1;
            left <= left - 9'd1;
            if (left == 9'd1)      st <= S_IDLE;
            else if (bidx == 3'd7) st <= S_LOAD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign scan_tck = chain_en & {NCH{st == S_SHIFT && ph}};
  assign scan_tdi = chain_en & {NCH{st == S_SHIFT && sreg[0]}};

  always_comb begin
    case (rd_addr)
      AW'(5'h00): rd_data = {busy, cnt_sat, 27'd0, ovf};
      AW'(5'h04): rd_data = 32'(chain_en);
      default:    rd_data = 32'd0;
    endcase
  end
endmodule

// File: rtl/scan_shift_engine_chk.sv
module scan_shift_engine_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] scan_tck,
  input logic [NCH-1:0] scan_tdi,
  input logic [NCH-1:0] chain_en,
  input logic           busy,
  input logic           ovf
);
  a_r7_single_tck: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(scan_tck));

  a_r7_tck_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (|scan_tck) |=> !(|scan_tck));

  a_r7_tdi_held: assert property (@(posedge clk) disable iff (!rst_n)
    (|scan_tck) |-> (scan_tdi == $past(scan_tdi)));

  a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ((scan_tck | scan_tdi) & ~chain_en) == '0);

  a_r2_en_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chain_en));

  a_r8_busy_clocking: assert property (@(posedge clk) disable iff (!rst_n)
    (|scan_tck) |-> busy);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
endmodule

bind scan_shift_engine scan_shift_engine_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .scan_tck(scan_tck), .scan_tdi(scan_tdi),
  .chain_en(chain_en), .busy(busy), .ovf(ovf)
);

// File: tb/scan_shift_engine_tb.sv
module scan_shift_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  scan_tdi, scan_tck;

  scan_shift_engine dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .scan_tdi(scan_tdi), .scan_tck(scan_tck)
  );

  always #5 clk = ~clk;

  int    n_chk = 0, n_bad = 0;
  bit    exp_q[$];
  int    len_q[$];
  logic [3:0] en_model = '0;
  string tag = "R1";
  logic [3:0] prev_tck = '0, prev_tdi = '0;
  logic  prev_busy = 1'b0;
  int    cur_bits = 0;
  bit    done = 0;

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  task automatic exp_pkt(int n);
    len_q.push_back(n);
  endtask

  task automatic exp_bits(int n, logic [31:0] v);
    for (int i = 0; i < n; i++) exp_q.push_back(v[i]);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    if (a == 5'h04 && $countones(d[3:0]) <= 1) en_model = d[3:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push_paced(logic [4:0] a, logic [31:0] d, int room);
    @(negedge clk);
    while (int'(rd_data[30:28]) > room) @(negedge clk);
    wr(a, d);
  endtask

  task automatic push_b(logic [7:0] d);  push_paced(5'h10, 32'(d), 6); endtask
  task automatic push_h(logic [15:0] d); push_paced(5'h14, 32'(d), 6); endtask
  task automatic push_w(logic [31:0] d); push_paced(5'h18, d, 4);      endtask

  task automatic drain();
    @(negedge clk);
    while (rd_data[31] || rd_data[30:28] != 3'd0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk({tag, " all expected bits shifted"}, 32'(exp_q.size()), 32'd0);
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && rd_addr == 5'h00) begin
      int ch;
      ch = 0;
      for (int i = 0; i < 4; i++) if (en_model[i]) ch = i;
      chk("R7 disabled chains quiet", 32'((scan_tck | scan_tdi) & ~en_model), 32'd0);
      if (|scan_tck) begin
        chk("R7 no back-to-back scan clock", 32'(prev_tck), 32'd0);
        chk("R7 data held over clock pulse", 32'(scan_tdi), 32'(prev_tdi));
        chk("R8 active while clocking", 32'(rd_data[31]), 32'd1);
        if (exp_q.size() == 0) chk({tag, " unexpected bit"}, 32'd1, 32'd0);
        else chk({tag, " shifted bit"}, 32'(scan_tdi[ch]), 32'(exp_q.pop_front()));
        cur_bits++;
      end
      if (prev_busy && !rd_data[31]) begin
        chk("R8 active drops after last clock", 32'(|prev_tck), 32'd1);
        if (len_q.size() == 0) chk("R8 unexpected packet end", 32'd1, 32'd0);
        else chk("R8 packet bit count", 32'(cur_bits), 32'(len_q.pop_front()));
        cur_bits = 0;
      end
      prev_tck  = scan_tck;
      prev_tdi  = scan_tdi;
      prev_busy = rd_data[31];
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after reset", rd_data, 32'd0);
    chk("R1 outputs after reset", {24'd0, scan_tck, scan_tdi}, 32'd0);
    rd_addr = 5'h04; #1;
    chk("R1 enable after reset", rd_data, 32'd0);

    tag = "R2";
    wr(5'h04, 32'h5);
    rd_addr = 5'h04; #1;
    chk("R2 two-bit enable ignored", rd_data, 32'd0);
    wr(5'h04, 32'h2);
    #1 chk("R2 single enable taken", rd_data, 32'h2);
    wr(5'h04, 32'h6);
    #1 chk("R2 multi-bit enable ignored", rd_data, 32'h2);
    rd_addr = 5'h00;

    tag = "R3";
    exp_pkt(16); exp_bits(16, 32'hA55A);
    push_b(8'h80); push_b(8'h0F); push_h(16'hA55A);
    exp_pkt(32); exp_bits(32, 32'h12345678);
    push_h(16'h1F80); push_w(32'h12345678);
    drain();

    tag = "R4";
    exp_pkt(8); exp_bits(8, 32'hC3);
    push_b(8'h3C); push_h(16'h0780); push_b(8'hC3);
    exp_pkt(1); exp_bits(1, 32'h1);
    push_h(16'h0080); push_b(8'h01);
    drain();

    tag = "R5";
    wr(5'h04, 32'h4);
    exp_pkt(12); exp_bits(12, 32'hBBAA);
    exp_pkt(8);  exp_bits(8, 32'h5A);
    push_h(16'h0B80); push_h(16'hBBAA); push_h(16'h0780); push_b(8'h5A);
    drain();

    tag = "R6";
    wr(5'h04, 32'h8);
    exp_pkt(128);
    exp_bits(32, 32'hDEADBEEF); exp_bits(32, 32'h0F1E2D3C);
    exp_bits(32, 32'h80000001); exp_bits(32, 32'h7A5C3E91);
    push_h(16'h7F80);
    push_w(32'hDEADBEEF); push_w(32'h0F1E2D3C);
    push_w(32'h80000001); push_w(32'h7A5C3E91);
    drain();
    chk("R10 no overflow under paced writes", 32'(rd_data[0]), 32'd0);

    tag = "R11";
    wr(5'h04, 32'h0);
    wr(5'h18, 32'h55AA0F80);
    chk("R9 count after one word", 32'(rd_data[30:28]), 32'd4);
    wr(5'h18, 32'h34120F80);
    chk("R9 count saturates when full", 32'(rd_data[30:28]), 32'd7);
    repeat (5) @(negedge clk);
    chk("R11 idle with no chain enabled", 32'(rd_data[31]), 32'd0);
    chk("R11 FIFO untouched", 32'(rd_data[30:28]), 32'd7);
    wr(5'h10, 32'hFF);
    chk("R10 overflow flag set", 32'(rd_data[0]), 32'd1);
    exp_pkt(16); exp_bits(16, 32'h55AA);
    exp_pkt(16); exp_bits(16, 32'h3412);
    tag = "R10";
    wr(5'h04, 32'h1);
    drain();
    chk("R10 overflow flag sticky", 32'(rd_data[0]), 32'd1);
    chk("R10 dropped byte not queued", 32'(rd_data[30:28]), 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule